// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for a single SDRAM read or write burst. A controller pulses `start_i` together with the first column of the burst and the decoded mode settings: a length code, the ordering (sequential or interleaved) and a flag that restricts writes to single beats. From the next clock the block emits one column per cycle with `valid_o` high, and marks the final beat with `last_o`.

Only the low column bits that the burst length covers change during a burst. They either count upward and wrap inside the aligned block, or are XORed with the beat index. The upper column bits keep the start value. A full-page burst walks the whole row upward and keeps running until `term_i` stops it. Settings that describe no burst are refused, and this is reported on `illegal_o`.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `illegal_o` are all low until a start pulse is accepted.
- R2: The length code is decoded as 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8 and 3'b111 = full page. A fixed-length burst gives exactly that many consecutive beats with `valid_o` high. `last_o` is high on the final beat only, and `valid_o` is low on the following cycle.
- R3: With `interleave_i` = 0 and burst length L, beat k carries the column whose upper bits equal those of the start column and whose low log2(L) bits equal (start low bits + k) mod L.
- R4: With `interleave_i` = 1 and burst length L, beat k carries the start column with its low log2(L) bits XORed with k. The upper bits are unchanged.
- R5: A sequential full-page burst outputs (start + k) mod 256 on beat k. It never raises `last_o` and does not stop by itself: beat 256 repeats the start column.
- R6: A full-page code with `interleave_i` = 1 starts no burst. `illegal_o` is high for exactly the one cycle after the start pulse, and `valid_o` stays low.
- R7: The reserved length codes 3'b100, 3'b101 and 3'b110 start no burst, and they raise `illegal_o` for one cycle as in R6.
- R8: When `single_write_i` = 1, a start with `is_write_i` = 1 produces a single beat at the start column with `last_o` high, whatever the length code. Reads, and writes with `single_write_i` = 0, use the programmed length.
- R9: `term_i` sampled high during an active burst, without a start pulse in the same cycle, makes `valid_o` low from the next cycle. `term_i` while idle has no effect on a later burst.
- R10: A start pulse during an active burst abandons it. The next cycle shows beat 0 of the new burst.
- R11: The first beat appears in the cycle after the start pulse is sampled. Later beats follow on every clock without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a new burst |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code (R2) |
| interleave_i | input | 1 | 0 sequential, 1 interleaved ordering |
| is_write_i | input | 1 | The burst being started is a write |
| single_write_i | input | 1 | Writes are single-beat accesses |
| term_i | input | 1 | Stop the active burst early |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` carries a beat |
| last_o | output | 1 | Current beat is the final one |
| illegal_o | output | 1 | Previous start was refused |

## Verification
The hardest case to reach is the wrap of a full-page burst past 256 beats back to its start column. An external stop must be held off for that long. To get there, the bench starts a full-page burst near the top of the row, watches 258 consecutive beats and only then raises the terminate request. The sequential and interleaved modes at lengths 1, 2, 4 and 8 are swept over every start column, so every wrap point inside an aligned block is covered. A restart is also issued in the middle of a burst, and terminate requests arrive both during a burst and while the block is idle.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE  = 3'b111
    } bl_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        logic   legal;
        logic   full_page;
        order_e order;
    } burst_mode_t;

    // log2 of the fixed burst length for a legal fixed-length code
    function automatic logic [1:0] len_log2(input logic [2:0] code);
        case (code)
            BL_TWO:   return 2'd1;
            BL_FOUR:  return 2'd2;
            BL_EIGHT: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             is_write_i,
    input  logic             single_write_i,
    output burst_mode_t      mode_o,
    output logic [COL_W-1:0] mask_o
);
    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    logic [1:0] lg;

    always_comb begin
        mode_o.order     = interleave_i ? ORD_XOR : ORD_SEQ;
        mode_o.full_page = 1'b0;
        mode_o.legal     = 1'b1;
        lg               = 2'd0;
        if (is_write_i && single_write_i) begin
            lg = 2'd0;
        end else begin
            case (len_code_i)
                BL_ONE, BL_TWO, BL_FOUR, BL_EIGHT: lg = len_log2(len_code_i);
                BL_PAGE: begin
                    mode_o.full_page = 1'b1;
                    mode_o.legal     = !interleave_i;
                end
                default: mode_o.legal = 1'b0;
            endcase
        end
        mask_o = mode_o.full_page ? ALL_ONES : ~(ALL_ONES << lg);
    end
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             legal_i,
    input  logic             full_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             term_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output logic             last_o
);
    logic             active_q;
    logic             full_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;

    assign last_o   = active_q && !full_q && (beat_q == mask_q);
    assign active_o = active_q;
    assign beat_o   = beat_q;
    assign mask_o   = mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            full_q   <= 1'b0;
            beat_q   <= '0;
            mask_q   <= '0;
        end else if (load_i) begin
            active_q <= legal_i;
            full_q   <= full_i;
            beat_q   <= '0;
            mask_q   <= mask_i;
        end else if (active_q) begin
            if (term_i || last_o) begin
                active_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/col_addr_calc.sv
module col_addr_calc
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] xor_low;

    always_comb begin
        seq_low = (start_i + beat_i) & mask_i;
        xor_low = (start_i ^ beat_i) & mask_i;
        col_o   = (start_i & ~mask_i) | ((order_i == ORD_XOR) ? xor_low : seq_low);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import sdram_burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             is_write_i,
    input  logic             single_write_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             illegal_o
);
    burst_mode_t      mode;
    logic [COL_W-1:0] mask_new;
    logic [COL_W-1:0] mask_cur;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] start_q;
    order_e           order_q;
    logic             illegal_q;
    logic             active;
    logic             last;

    burst_mode_decode #(.COL_W(COL_W)) dec_i (
        .len_code_i     (len_code_i),
        .interleave_i   (interleave_i),
        .is_write_i     (is_write_i),
        .single_write_i (single_write_i),
        .mode_o         (mode),
        .mask_o         (mask_new)
    );

    burst_beat_seq #(.COL_W(COL_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (start_i),
        .legal_i  (mode.legal),
        .full_i   (mode.full_page),
        .mask_i   (mask_new),
        .term_i   (term_i),
        .active_o (active),
        .beat_o   (beat),
        .mask_o   (mask_cur),
        .last_o   (last)
    );

    col_addr_calc #(.COL_W(COL_W)) calc_i (
        .start_i (start_q),
        .beat_i  (beat),
        .mask_i  (mask_cur),
        .order_i (order_q),
        .col_o   (col_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q   <= '0;
            order_q   <= ORD_SEQ;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= start_i && !mode.legal;
            if (start_i) begin
                start_q <= start_col_i;
                order_q <= mode.order;
            end
        end
    end

    assign valid_o   = active;
    assign last_o    = last;
    assign illegal_o = illegal_q;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             interleave_i,
    input logic             is_write_i,
    input logic             single_write_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             illegal_o
);
    // R2
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    // R2
    stop_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && last_o && !start_i) |=> !valid_o);

    // R11
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !term_i && !start_i) |=> valid_o);

    // R9
    term_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && term_i && !start_i) |=> !valid_o);

    // R6
    page_xor_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && len_code_i == 3'b111 && interleave_i && !(is_write_i && single_write_i))
        |=> (illegal_o && !valid_o));

    // R7
    reserved_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && len_code_i[2] && len_code_i != 3'b111 && !(is_write_i && single_write_i))
        |=> (illegal_o && !valid_o));

    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && is_write_i && single_write_i)
        |=> (valid_o && last_o && col_o == $past(start_col_i)));

    // R10
    restart_first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && len_code_i == 3'b000)
        |=> (valid_o && last_o && col_o == $past(start_col_i)));

    // R6
    illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !valid_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .start_col_i    (start_col_i),
    .len_code_i     (len_code_i),
    .interleave_i   (interleave_i),
    .is_write_i     (is_write_i),
    .single_write_i (single_write_i),
    .term_i         (term_i),
    .col_o          (col_o),
    .valid_o        (valid_o),
    .last_o         (last_o),
    .illegal_o      (illegal_o)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = 3'b000;
    logic             interleave_i = 1'b0;
    logic             is_write_i = 1'b0;
    logic             single_write_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             illegal_o;

    int nvec  = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .interleave_i(interleave_i), .is_write_i(is_write_i),
        .single_write_i(single_write_i), .term_i(term_i), .col_o(col_o),
        .valid_o(valid_o), .last_o(last_o), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_col(input int s, input int k, input int len, input bit inter, input bit page);
        int base;
        int off;
        if (page) return (s + k) % 256;
        off  = s % len;
        base = s - off;
        if (inter) return base + (off ^ k);
        return base + ((off + k) % len);
    endfunction

    task automatic pulse_start(input int s, input logic [2:0] code, input bit inter,
                               input bit wr, input bit sw);
        start_i        = 1'b1;
        start_col_i    = COL_W'(s);
        len_code_i     = code;
        interleave_i   = inter;
        is_write_i     = wr;
        single_write_i = sw;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Observe n beats; the first is visible right after the start pulse.
    task automatic watch_beats(input int s, input int n, input int len, input bit inter,
                               input bit page, input string req);
        for (int k = 0; k < n; k++) begin
            chk(valid_o === 1'b1, req, int'(valid_o), 1);
            chk(int'(col_o) == exp_col(s, k, len, inter, page), req, int'(col_o),
                exp_col(s, k, len, inter, page));
            chk(last_o === (!page && k == len - 1), req, int'(last_o), int'(!page && k == len - 1));
            if (k != n - 1) @(negedge clk);
        end
    endtask

    task automatic full_burst(input int s, input logic [2:0] code, input int len,
                              input bit inter, input bit wr, input bit sw, input string req);
        pulse_start(s, code, inter, wr, sw);
        watch_beats(s, len, len, inter, 1'b0, req);
        @(negedge clk);
        chk(valid_o === 1'b0, req, int'(valid_o), 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(valid_o === 1'b0 && last_o === 1'b0 && illegal_o === 1'b0, "R1", int'(valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(valid_o === 1'b0 && illegal_o === 1'b0, "R1", int'(valid_o), 0);

        // R2 R3 R4 R11: sweep every start column for each fixed length and order
        for (int c = 0; c < 4; c++) begin
            for (int inter = 0; inter < 2; inter++) begin
                for (int s = 0; s < 256; s++) begin
                    full_burst(s, 3'(c), 1 << c, inter[0], 1'b0, 1'b0,
                               inter != 0 ? "R4" : (c == 0 ? "R2" : "R3"));
                end
            end
        end

        // R11 R3: named example, length 4 sequential from 2 gives 2-3-0-1
        pulse_start(2, 3'b010, 1'b0, 1'b0, 1'b0);
        chk(col_o == 8'd2, "R11", int'(col_o), 2);
        @(negedge clk); chk(col_o == 8'd3, "R3", int'(col_o), 3);
        @(negedge clk); chk(col_o == 8'd0, "R3", int'(col_o), 0);
        @(negedge clk); chk(col_o == 8'd1 && last_o, "R3", int'(col_o), 1);
        @(negedge clk);

        // R5: full page from 250, run past the wrap, then terminate (R9)
        pulse_start(250, 3'b111, 1'b0, 1'b0, 1'b0);
        watch_beats(250, 258, 256, 1'b0, 1'b1, "R5");
        chk(col_o == 8'd251, "R5", int'(col_o), 251);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk(valid_o === 1'b0, "R9", int'(valid_o), 0);

        // R6: interleaved full page refused
        pulse_start(16, 3'b111, 1'b1, 1'b0, 1'b0);
        chk(illegal_o === 1'b1 && valid_o === 1'b0, "R6", int'(illegal_o), 1);
        @(negedge clk);
        chk(illegal_o === 1'b0 && valid_o === 1'b0, "R6", int'(illegal_o), 0);

        // R7: reserved codes refused
        for (int c = 4; c < 7; c++) begin
            pulse_start(9, 3'(c), 1'b0, 1'b0, 1'b0);
            chk(illegal_o === 1'b1 && valid_o === 1'b0, "R7", int'(illegal_o), 1);
            @(negedge clk);
            chk(illegal_o === 1'b0 && valid_o === 1'b0, "R7", int'(valid_o), 0);
        end

        // R8: single-beat writes, reads keep length, writes keep length with mode off
        full_burst(37, 3'b011, 1, 1'b0, 1'b1, 1'b1, "R8");
        full_burst(37, 3'b111, 1, 1'b1, 1'b1, 1'b1, "R8");
        full_burst(37, 3'b011, 8, 1'b1, 1'b0, 1'b1, "R8");
        full_burst(37, 3'b011, 8, 1'b0, 1'b1, 1'b0, "R8");

        // R9: terminate mid-burst; terminate while idle is ignored
        pulse_start(3, 3'b011, 1'b0, 1'b0, 1'b0);
        watch_beats(3, 3, 8, 1'b0, 1'b0, "R9");
        term_i = 1'b1;
        @(negedge clk);
        chk(valid_o === 1'b0, "R9", int'(valid_o), 0);
        @(negedge clk);
        chk(valid_o === 1'b0, "R9", int'(valid_o), 0);
        term_i = 1'b0;
        full_burst(12, 3'b010, 4, 1'b0, 1'b0, 1'b0, "R9");

        // R10: restart during a burst with a new address and order
        pulse_start(0, 3'b011, 1'b0, 1'b0, 1'b0);
        watch_beats(0, 2, 8, 1'b0, 1'b0, "R10");
        full_burst(8'h45, 3'b010, 4, 1'b1, 1'b0, 1'b0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule